// File: doc/BRIEF.md
# Two-Point Cell-Voltage Calibrator with Reference Drift Tracking

This block turns raw ADC codes from a multiplexed cell monitor into corrected cell voltages in microvolts. Each accepted sample carries a channel index and a code. The block remembers the newest reading of every channel. Two capture commands copy those readings into a stored-zero file and a stored-full-scale file. Host software issues the zero capture while 0 V is on every input, and the full-scale capture while the reference voltage (1.25 V by default) is on every input. The per-channel stored pair removes that channel's own offset and gain mismatch.

Two channels are wired to fixed references: the low reference at 0 V and the high reference at the reference voltage. Their live readings, compared with their stored readings, give an offset shift and a gain ratio. Both are applied to every channel, so a common temperature drift cancels. The scaling needs one division, done by a multi-cycle restoring divider. A per-channel first-order exponential smoother with a coefficient near 0.1 can follow the correction.

Top module: `cal_two_point`

## Requirements
- R1: During reset and straight after it, out_valid, err and busy are 0, and out_data and out_ch are 0.
- R2: A sample is accepted when in_valid is 1 and busy is 0. The accepted code becomes the live reading of channel in_ch. The correction of that same sample uses the live readings held before it.
- R3: A cycle with cmd_zero at 1 copies every channel's live reading into the stored-zero file. A cycle with cmd_full at 1 copies them into the stored-full file.
- R4: Channel 6 is the 0 V reference and channel 7 is the high reference. Let d = live6 − zero6, Sl = live7 − zero7 − d, Ss = full7 − zero7 and Sc = full[c] − zero[c]. The result for code x on channel c is floor(max(0, x − zero[c] − d) · 1250000 · Ss / (Sc · Sl)), in units of 1 µV.
- R5: When x − zero[c] − d is zero or negative, the result is exactly 0.
- R6: A result above 2^OUT_W − 1 is clamped to 2^OUT_W − 1.
- R7: If Sc ≤ 0, Ss ≤ 0 or Sl ≤ 0, err is 1 for one cycle, in the cycle after acceptance. In that case out_valid stays 0, out_data and out_ch keep their values, and the smoothing state is unchanged.
- R8: After a valid acceptance, busy stays 1 until the result is delivered. A sample offered while busy is 1 is ignored completely, and it does not change any live reading.
- R9: Each result appears as a one-cycle out_valid pulse, together with out_data and the sample's out_ch. out_valid and err are never 1 in the same cycle.
- R10: filt_en is sampled when the result is delivered. If filt_en is 1, out_data = s + floor((r − s)·205/2048), where r is the R4–R6 result and s is that channel's previous out_data (0 after reset). If filt_en is 0, out_data = r. In both cases, s then becomes out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ch | input | $clog2(NCH) | Channel of the sample |
| in_code | input | CODE_W | Raw ADC code |
| cmd_zero | input | 1 | Capture live readings as stored zero |
| cmd_full | input | 1 | Capture live readings as stored full scale |
| filt_en | input | 1 | Enable exponential smoothing |
| busy | output | 1 | Division in progress; samples are ignored |
| out_valid | output | 1 | Result pulse |
| out_ch | output | $clog2(NCH) | Channel of the result |
| out_data | output | OUT_W | Corrected value in µV |
| err | output | 1 | Degenerate span pulse |

## Verification
The bench sweeps every code of a 10-bit configuration on one channel. This exposes any off-by-one in the zero clamp at the threshold, and any rounding or width fault in the product and quotient. A narrowed stored span drives the quotient past the output width; a missing clamp would return wrapped low bits. Equal spans, inverted spans and an inverted live reference span must raise err and leave the output untouched. A design that divided anyway would emit garbage with a valid pulse. Samples offered while busy aim at the low reference. If they leaked into the live file, the next measurement would shift by the offset change. The filter sequence checks that a rejected sample does not disturb the per-channel state.

// File: rtl/cal_pkg.sv
// Shared constants and types for the two-point calibrator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cal_pkg;
    // Default reference voltage in microvolts.
    localparam int unsigned CAL_SPAN_UV_DEF = 1250000;
    // Default smoothing coefficient numerator and shift (205/2048 ~ 0.1).
    localparam int unsigned CAL_FILT_NUM_DEF = 205;
    localparam int unsigned CAL_FILT_SH_DEF  = 11;

    // Phase of the restoring divider.
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } cal_div_phase_e;
endpackage

// File: rtl/cal_regfile.sv
// Live / stored-zero / stored-full reading files, one entry per channel.
// Assumes wr_ch < NCH. A capture copies the live values held before the edge.
module cal_regfile #(
    parameter int NCH    = 8,
    parameter int CODE_W = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              cap_zero,
    input  logic              cap_full,
    output logic [CODE_W-1:0] live_o [NCH],
    output logic [CODE_W-1:0] zero_o [NCH],
    output logic [CODE_W-1:0] full_o [NCH]
);
    logic [CODE_W-1:0] live_q [NCH];
    logic [CODE_W-1:0] zero_q [NCH];
    logic [CODE_W-1:0] full_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Per-channel storage: live write and the two capture copies.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[g] <= '0;
                zero_q[g] <= '0;
                full_q[g] <= '0;
            end else begin
                if (wr_en && (wr_ch == CH_W'(g))) live_q[g] <= wr_code;
                if (cap_zero) zero_q[g] <= live_q[g];
                if (cap_full) full_q[g] <= live_q[g];
            end
        end

        assign live_o[g] = live_q[g];
        assign zero_o[g] = zero_q[g];
        assign full_o[g] = full_q[g];

        // R3: a zero capture holds the previous live reading
        a_r3_cap_zero: assert property (@(posedge clk) disable iff (!rst_n)
            cap_zero |=> zero_q[g] == $past(live_q[g]));
        // R3: a full capture holds the previous live reading
        a_r3_cap_full: assert property (@(posedge clk) disable iff (!rst_n)
            cap_full |=> full_q[g] == $past(live_q[g]));
    end
endmodule

// File: rtl/cal_operands.sv
// Combinational operand builder: forms the dividend and divisor of the
// correction from the sample and the reading files, and flags degenerate spans.
// Assumes ch < NCH and the reference channels are valid indices.
module cal_operands #(
    parameter int NCH      = 8,
    parameter int CODE_W   = 16,
    parameter int REF_LO   = 6,
    parameter int REF_HI   = 7,
    parameter int SPAN_UV  = 1250000,
    localparam int CH_W    = $clog2(NCH),
    localparam int FS_W    = $clog2(SPAN_UV + 1),
    localparam int SW      = CODE_W + 3,
    localparam int MAG_W   = CODE_W + 2,
    localparam int NUM_W   = MAG_W + FS_W + CODE_W,
    localparam int DEN_W   = CODE_W + MAG_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CH_W-1:0]   ch,
    input  logic [CODE_W-1:0] live_i [NCH],
    input  logic [CODE_W-1:0] zero_i [NCH],
    input  logic [CODE_W-1:0] full_i [NCH],
    output logic [NUM_W-1:0]  num,
    output logic [DEN_W-1:0]  den,
    output logic              bad
);
    logic signed [SW-1:0] d_off, s_live, s_store, s_chan, diff;
    logic [MAG_W-1:0]     diff_mag, slive_mag;
    logic [CODE_W-1:0]    sstore_mag, schan_mag;
    logic                 diff_pos;

    // Sign-extend helper done inline: every code widened with zeros to SW.
    always_comb begin
        d_off   = $signed({3'b000, live_i[REF_LO]}) - $signed({3'b000, zero_i[REF_LO]});
        s_live  = $signed({3'b000, live_i[REF_HI]}) - $signed({3'b000, zero_i[REF_HI]}) - d_off;
        s_store = $signed({3'b000, full_i[REF_HI]}) - $signed({3'b000, zero_i[REF_HI]});
        s_chan  = $signed({3'b000, full_i[ch]})     - $signed({3'b000, zero_i[ch]});
        diff    = $signed({3'b000, code})           - $signed({3'b000, zero_i[ch]}) - d_off;
    end

    // Degenerate-span detection and magnitude extraction.
    always_comb begin
        bad = s_chan[SW-1]  || (s_chan  == '0) ||
              s_store[SW-1] || (s_store == '0) ||
              s_live[SW-1]  || (s_live  == '0);
        diff_pos   = !diff[SW-1] && (diff != '0);
        diff_mag   = diff_pos ? diff[MAG_W-1:0] : '0;
        slive_mag  = s_live[MAG_W-1:0];
        sstore_mag = s_store[CODE_W-1:0];
        schan_mag  = s_chan[CODE_W-1:0];
    end

    // Dividend and divisor products.
    always_comb begin
        num = NUM_W'(diff_mag) * NUM_W'(SPAN_UV) * NUM_W'(sstore_mag);
        den = DEN_W'(schan_mag) * DEN_W'(slive_mag);
    end
endmodule

// File: rtl/cal_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Loads on start while idle, runs NUM_W cycles, then holds DONE for one cycle.
// Assumes den is non-zero whenever start is raised.
module cal_divider
    import cal_pkg::*;
#(
    parameter int NUM_W  = 55,
    parameter int DEN_W  = 34,
    localparam int CNT_W  = $clog2(NUM_W),
    localparam int PROD_W = NUM_W + DEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    cal_div_phase_e     phase;
    logic [NUM_W-1:0]   num_q, quo_q;
    logic [DEN_W-1:0]   den_q, rem_q, rem_sub, rem_n;
    logic [DEN_W:0]     trial;
    logic [CNT_W-1:0]   cnt;
    logic               ge;

    // One restoring step: shift in the next dividend bit and try subtracting.
    always_comb begin
        trial   = {rem_q, quo_q[NUM_W-1]};
        ge      = trial >= {1'b0, den_q};
        rem_sub = trial[DEN_W-1:0] - den_q;
        rem_n   = ge ? rem_sub : trial[DEN_W-1:0];
    end

    // Phase sequencing and iteration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= DIV_IDLE;
            num_q <= '0;
            den_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                DIV_IDLE: if (start) begin
                    num_q <= num;
                    den_q <= den;
                    quo_q <= num;
                    rem_q <= '0;
                    cnt   <= '0;
                    phase <= DIV_RUN;
                end
                DIV_RUN: begin
                    rem_q <= rem_n;
                    quo_q <= {quo_q[NUM_W-2:0], ge};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_W'(NUM_W - 1)) phase <= DIV_DONE;
                end
                default: phase <= DIV_IDLE;
            endcase
        end
    end

    assign busy = (phase != DIV_IDLE);
    assign done = (phase == DIV_DONE);
    assign quo  = quo_q;

    // R4: the delivered quotient and remainder satisfy the division identity
    a_r4_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((PROD_W'(quo_q) * PROD_W'(den_q) + PROD_W'(rem_q)) == PROD_W'(num_q))
                 && (rem_q < den_q));
endmodule

// File: rtl/cal_smooth.sv
// Per-channel first-order exponential smoother with a fixed-point coefficient.
// The state of a channel is its last delivered output; upd writes it.
// Assumes ch < NCH and FILT_NUM < 2**FILT_SH.
module cal_smooth #(
    parameter int NCH      = 8,
    parameter int OUT_W    = 24,
    parameter int FILT_NUM = 205,
    parameter int FILT_SH  = 11,
    localparam int CH_W    = $clog2(NCH),
    localparam int FN_W    = $clog2(FILT_NUM + 1) + 1,
    localparam int P_W     = OUT_W + 1 + FN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CH_W-1:0]  ch,
    input  logic [OUT_W-1:0] q,
    input  logic             filt_en,
    output logic [OUT_W-1:0] y
);
    logic [OUT_W-1:0]        st_q [NCH];
    logic [OUT_W-1:0]        sel;
    logic signed [OUT_W:0]   delta;
    logic signed [FN_W-1:0]  coef;
    logic signed [P_W-1:0]   prod, step, sum;

    // Filtered candidate: state plus the scaled difference, floor rounding.
    always_comb begin
        sel   = st_q[ch];
        delta = $signed({1'b0, q}) - $signed({1'b0, sel});
        coef  = FN_W'(FILT_NUM);
        prod  = delta * coef;
        step  = prod >>> FILT_SH;
        sum   = $signed({{(P_W - OUT_W){1'b0}}, sel}) + step;
        y     = filt_en ? sum[OUT_W-1:0] : q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_st
        // Channel state follows the delivered output.
        always_ff @(posedge clk) begin
            if (!rst_n)                          st_q[g] <= '0;
            else if (upd && (ch == CH_W'(g)))    st_q[g] <= y;
        end
    end

    // R10: the filtered value lies between the old state and the new result
    a_r10_filter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && filt_en) |->
            ((sum >= $signed({{(P_W - OUT_W){1'b0}}, (sel < q) ? sel : q})) &&
             (sum <= $signed({{(P_W - OUT_W){1'b0}}, (sel < q) ? q : sel}))));
endmodule

// File: rtl/cal_two_point.sv
// Two-point calibrator top: records live readings, captures zero/full files,
// corrects each sample against per-channel spans and reference drift through a
// multi-cycle divider, clamps, optionally smooths, and reports a result or error.
// Assumes NCH is a power of two and the reference indices are below NCH.
module cal_two_point
    import cal_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CODE_W   = 16,
    parameter int OUT_W    = 24,
    parameter int REF_LO   = 6,
    parameter int REF_HI   = 7,
    parameter int SPAN_UV  = CAL_SPAN_UV_DEF,
    parameter int FILT_NUM = CAL_FILT_NUM_DEF,
    parameter int FILT_SH  = CAL_FILT_SH_DEF,
    localparam int CH_W    = $clog2(NCH),
    localparam int FS_W    = $clog2(SPAN_UV + 1),
    localparam int MAG_W   = CODE_W + 2,
    localparam int NUM_W   = MAG_W + FS_W + CODE_W,
    localparam int DEN_W   = CODE_W + MAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [CODE_W-1:0] in_code,
    input  logic              cmd_zero,
    input  logic              cmd_full,
    input  logic              filt_en,
    output logic              busy,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [OUT_W-1:0]  out_data,
    output logic              err
);
    logic [CODE_W-1:0] live_w [NCH];
    logic [CODE_W-1:0] zero_w [NCH];
    logic [CODE_W-1:0] full_w [NCH];
    logic [NUM_W-1:0]  num_w, quo_w;
    logic [DEN_W-1:0]  den_w;
    logic [OUT_W-1:0]  q_sat, y_w;
    logic [CH_W-1:0]   ch_q;
    logic              bad_w, accept, div_busy, div_done;

    assign accept = in_valid && !div_busy;
    assign busy   = div_busy;

    cal_regfile #(.NCH(NCH), .CODE_W(CODE_W)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_ch    (in_ch),
        .wr_code  (in_code),
        .cap_zero (cmd_zero),
        .cap_full (cmd_full),
        .live_o   (live_w),
        .zero_o   (zero_w),
        .full_o   (full_w)
    );

    cal_operands #(.NCH(NCH), .CODE_W(CODE_W), .REF_LO(REF_LO), .REF_HI(REF_HI),
                   .SPAN_UV(SPAN_UV)) u_operands (
        .code   (in_code),
        .ch     (in_ch),
        .live_i (live_w),
        .zero_i (zero_w),
        .full_i (full_w),
        .num    (num_w),
        .den    (den_w),
        .bad    (bad_w)
    );

    cal_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_divider (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept && !bad_w),
        .num   (num_w),
        .den   (den_w),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (quo_w)
    );

    // Clamp the quotient to the output width.
    always_comb begin
        q_sat = (|quo_w[NUM_W-1:OUT_W]) ? {OUT_W{1'b1}} : quo_w[OUT_W-1:0];
    end

    cal_smooth #(.NCH(NCH), .OUT_W(OUT_W), .FILT_NUM(FILT_NUM),
                 .FILT_SH(FILT_SH)) u_smooth (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (div_done),
        .ch      (ch_q),
        .q       (q_sat),
        .filt_en (filt_en),
        .y       (y_w)
    );

    // Latch the channel of the sample in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)      ch_q <= '0;
        else if (accept) ch_q <= in_ch;
    end

    // Result and error reporting registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ch    <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= div_done;
            err       <= accept && bad_w;
            if (div_done) begin
                out_data <= y_w;
                out_ch   <= ch_q;
            end
        end
    end

    // R9: result and error never coincide
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && err));
    // R9: a result pulse lasts one cycle
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R7: an error leaves the reported output untouched
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(out_data) && $stable(out_ch)));
    // R8: a valid acceptance makes the block busy
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bad_w) |=> busy);
endmodule

// File: tb/test_cal_two_point.sv
`timescale 1ns/1ps
module test_cal_two_point;
    localparam int NCH = 8, CODE_W = 10, OUT_W = 24;
    localparam longint OMAX = (64'd1 << OUT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, cmd_zero = 1'b0, cmd_full = 1'b0, filt_en = 1'b0;
    logic [2:0] in_ch = '0;
    logic [CODE_W-1:0] in_code = '0;
    logic busy, out_valid, err;
    logic [2:0] out_ch;
    logic [OUT_W-1:0] out_data;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    longint m_live [NCH], m_zero [NCH], m_full [NCH], m_state [NCH];
    longint last_data = 0, last_ch = 0;

    always #2 clk = ~clk;

    cal_two_point #(.NCH(NCH), .CODE_W(CODE_W), .OUT_W(OUT_W)) i_cal_two_point (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_code(in_code),
        .cmd_zero(cmd_zero), .cmd_full(cmd_full), .filt_en(filt_en), .busy(busy),
        .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data), .err(err));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model of R4-R7 using the pre-sample reading files.
    task automatic model(input int ch, input longint x, output bit bad, output longint q);
        longint d, sl, ss, sc, df;
        d  = m_live[6] - m_zero[6];
        sl = m_live[7] - m_zero[7] - d;
        ss = m_full[7] - m_zero[7];
        sc = m_full[ch] - m_zero[ch];
        bad = (sc <= 0) || (ss <= 0) || (sl <= 0);
        df = x - m_zero[ch] - d;
        if (df < 0) df = 0;
        q = 0;
        if (!bad) begin
            q = (df * 1250000 * ss) / (sc * sl);
            if (q > OMAX) q = OMAX;
        end
    endtask

    function automatic longint smooth(input int ch, input longint q);
        if (filt_en) return m_state[ch] + (((q - m_state[ch]) * 205) >>> 11);
        return q;
    endfunction

    task automatic wait_result(input int ch, input longint y, input string req);
        int n = 0;
        while (out_valid !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(out_valid === 1'b1 && out_data == y && out_ch == ch, req, out_data, y);
        m_state[ch] = y;
        last_data = y;
        last_ch = ch;
        @(negedge clk);
    endtask

    task automatic send(input int ch, input int code, input string req);
        bit bad;
        longint q, y;
        model(ch, code, bad, q);
        y = smooth(ch, q);
        @(negedge clk);
        in_valid = 1'b1; in_ch = 3'(ch); in_code = CODE_W'(code);
        @(negedge clk);
        in_valid = 1'b0;
        m_live[ch] = code;
        if (bad) begin
            chk(err === 1'b1 && out_valid === 1'b0, req, err, 1);
            chk(out_data == last_data && out_ch == last_ch, req, out_data, last_data);
        end else begin
            wait_result(ch, y, req);
        end
    endtask

    task automatic capture(input bit z);
        @(negedge clk);
        if (z) cmd_zero = 1'b1; else cmd_full = 1'b1;
        @(negedge clk);
        cmd_zero = 1'b0; cmd_full = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (z) m_zero[c] = m_live[c]; else m_full[c] = m_live[c];
        end
    endtask

    initial begin
        bit bad;
        longint q, y;
        for (int c = 0; c < NCH; c++) begin
            m_live[c] = 0; m_zero[c] = 0; m_full[c] = 0; m_state[c] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs quiet in reset and just after it
        chk(out_valid === 1'b0 && err === 1'b0 && busy === 1'b0, "R1", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_data == 0 && out_ch == 0 && busy === 1'b0, "R1", out_data, 0);

        // R7: empty files give equal spans, then inverted spans after the zero capture
        for (int c = 0; c < NCH; c++) send(c, 60 + 5 * c, "R7");
        capture(1'b1);
        for (int c = 0; c < NCH; c++) send(c, 600 + 11 * c, "R7");
        capture(1'b0);

        // R2: reference channels set up; each sample corrected with the old readings
        send(6, 92, "R2");
        send(7, 670, "R2");

        // R4 / R5: exhaustive code sweep on channel 2 (zero clamp for code <= 72)
        for (int code = 0; code < (1 << CODE_W); code++)
            send(2, code, (code <= 72) ? "R5" : "R4");

        // R6: one-code stored span on channel 1 forces the clamp
        send(1, 66, "R3");
        capture(1'b0);
        send(1, 1000, "R6");
        send(1, 200, "R6");

        // R10: smoothing sequences on two channels
        filt_en = 1'b1;
        send(2, 800, "R10");
        send(2, 800, "R10");
        send(2, 800, "R10");
        send(2, 300, "R10");
        send(2, 1023, "R10");
        send(3, 900, "R10");
        send(2, 0, "R10");

        // R7: inverted live reference span, and filter state left unchanged
        send(7, 90, "R10");
        send(4, 500, "R7");
        send(7, 670, "R7");
        send(2, 800, "R7");
        filt_en = 1'b0;

        // R8: samples offered while busy are ignored
        model(2, 500, bad, q);
        y = smooth(2, q);
        @(negedge clk);
        in_valid = 1'b1; in_ch = 3'd2; in_code = 10'd500;
        @(negedge clk);
        m_live[2] = 500;
        in_ch = 3'd6; in_code = 10'd0;
        chk(busy === 1'b1, "R8", busy, 1);
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        wait_result(2, y, "R8");
        send(3, 700, "R8");
        send(5, 300, "R8");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule